// File: doc/BRIEF.md
# Multi-Burst AXI4 Write Master

This block turns one write request from user logic into a chain of AXI4 write bursts. The request gives a start address and a total length in data beats. The length may cover any number of bursts. Every burst is a fixed 256-beat INCR burst of 32-byte beats. The block sends one address per burst and streams the user's beats onto the write data channel. It waits for each write response before it starts the next burst. Each new burst address is the previous one plus 0x2000. An upper address limit input keeps bursts from running past the end of the memory window; a burst that would cross it restarts at address zero.

The user side behaves like a FIFO write port. Data is taken on a valid/ready handshake, and ready gives backpressure. A last flag lets the user end the data stream early. The final burst is always completed to 256 beats with zero data. `busy` is high from the cycle after a request is accepted until the final write response has been taken. A non-OKAY response sets a sticky error flag. The block is held in synchronous reset while `rst` is high or while `init_done` (memory ready) is low.

Top module: `axi_burst_writer`

## Requirements
- R1: While `rst` is high or `init_done` is low, `busy`, `err`, `wr_ready`, `m_awvalid` and `m_wvalid` are all low.
- R2: A `req_en` pulse with a non-zero `req_len` while idle is accepted. `busy` is high from the next cycle, and the first burst address equals `req_addr`. A pulse with `req_len` of zero is ignored.
- R3: Every address handshake carries `m_awlen` 8'hFF (256 beats), `m_awsize` 3'b101 (32 bytes), `m_awburst` 2'b01 (INCR), and zero id, lock, cache, prot and qos. Every data beat has `m_wstrb` all ones.
- R4: The number of bursts is `req_len` divided by 256, rounded up. User beats appear on `m_wdata` in order, and the beats after the last user beat in the final burst carry all-zero data.
- R5: `m_wlast` is high on the 256th beat of each burst and on no other beat.
- R6: A burst address is issued only after the write response of the previous burst has been taken. Each following address is the previous address plus 0x2000.
- R7: If the next address plus 0x1FFF would exceed `addr_limit` (or overflow 32 bits), the next burst starts at address 0 instead.
- R8: A user beat taken with `wr_last` high is the final user beat. The rest of that burst is filled with zero data and no further burst is issued.
- R9: `busy` falls in the cycle after the final burst's write response handshake. `req_en` pulses are ignored while `busy` is high, including in the cycle of that final response.
- R10: `wr_ready` is high only while a burst's data phase has a free output slot. `m_awvalid` with its address, and `m_wvalid` with its data and last flag, are held stable until accepted.
- R11: A write response other than OKAY (2'b00) sets `err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | input | 1 | Memory ready; low holds the block in reset |
| req_en | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Start byte address of the transfer |
| req_len | input | LEN_W | Total transfer length in beats |
| addr_limit | input | ADDR_W | Highest byte address a burst may touch |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky error from a non-OKAY response |
| wr_data | input | DATA_W | User data beat |
| wr_valid | input | 1 | User beat valid |
| wr_last | input | 1 | Final user beat of this request |
| wr_ready | output | 1 | Block can take a user beat |
| m_awid | output | ID_W | Write address id (zero) |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Burst length code |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_awlock | output | 1 | Lock (zero) |
| m_awcache | output | 4 | Cache attributes (zero) |
| m_awprot | output | 3 | Protection (zero) |
| m_awqos | output | 4 | QoS (zero) |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Last beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The write response that ends a request can arrive in the same cycle as a new `req_en` pulse. The bench provokes this by raising a stray request in exactly the cycle its slave model asserts the final response. The block must ignore that request. The bench judges this by the `busy` trace and by the absence of any extra burst address.

A second coincidence is a user beat being taken into the output register in the same cycle the previous beat leaves on the write channel. Pseudo-random ready stalls from the slave, mixed with gaps on the user side, exercise both the drain-and-refill cycle and the hold cycle. Every beat's data and last flag are compared against a queue built when the request was accepted.

// File: rtl/awb_pkg.sv
package awb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } wr_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W:0] STRIDE_X = (ADDR_W+1)'(STRIDE);

  logic [ADDR_W:0] nxt;
  logic [ADDR_W:0] span_end;
  logic            wrap;

  // span_end is the last byte the following burst would touch
  always_comb begin
    nxt      = {1'b0, addr} + STRIDE_X;
    span_end = nxt + STRIDE_X - (ADDR_W+1)'(1);
    wrap     = nxt[ADDR_W] | span_end[ADDR_W] | (span_end > {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= start;
    end else if (step) begin
      addr <= wrap ? '0 : nxt[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/wbeat_feeder.sv
module wbeat_feeder #(
  parameter int DATA_W = 256,
  parameter int BEATS  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              more,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              take,
  output logic [DATA_W-1:0] wdata,
  output logic              wvalid,
  output logic              wlast,
  input  logic              wready,
  output logic              burst_end
);
  localparam int CW = $clog2(BEATS) + 1;

  logic [CW-1:0] loaded;
  logic          slot;
  logic          pad;
  logic          ld;

  always_comb begin
    slot      = active && (loaded != CW'(BEATS)) && (!wvalid || wready);
    in_ready  = slot && more;
    take      = in_ready && in_valid;
    pad       = slot && !more;
    ld        = take || pad;
    burst_end = wvalid && wready && wlast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= '0;
      wvalid <= 1'b0;
      wlast  <= 1'b0;
      wdata  <= '0;
    end else begin
      if (ld) begin
        wdata  <= pad ? '0 : in_data;
        wvalid <= 1'b1;
        wlast  <= (loaded == CW'(BEATS - 1));
      end else if (wvalid && wready) begin
        wvalid <= 1'b0;
      end
      if (burst_end) begin
        loaded <= '0;
      end else if (ld) begin
        loaded <= loaded + CW'(1);
      end
    end
  end
endmodule

// File: rtl/axi_burst_writer.sv
module axi_burst_writer
  import awb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 256,
  parameter int BEATS  = 256,
  parameter int LEN_W  = 32,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init_done,
  input  logic                req_en,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [ADDR_W-1:0]   addr_limit,
  output logic                busy,
  output logic                err,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_valid,
  input  logic                wr_last,
  output logic                wr_ready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awlock,
  output logic [3:0]          m_awcache,
  output logic [2:0]          m_awprot,
  output logic [3:0]          m_awqos,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready
);
  localparam int BYTES  = DATA_W / 8;
  localparam int STRIDE = BEATS * BYTES;

  wr_state_e        state;
  logic             srst;
  logic             accept;
  logic             step;
  logic             take;
  logic             burst_end;
  logic             user_done;
  logic [LEN_W-1:0] user_left;
  logic             awvalid_q;
  logic             bready_q;
  logic             err_q;

  assign srst   = rst || !init_done;
  assign accept = (state == ST_IDLE) && req_en && (req_len != '0);
  assign step   = (state == ST_RESP) && m_bvalid && !user_done;

  // fixed burst attributes
  assign m_awid    = '0;
  assign m_awlen   = 8'(BEATS - 1);
  assign m_awsize  = 3'($clog2(BYTES));
  assign m_awburst = BURST_INCR;
  assign m_awlock  = 1'b0;
  assign m_awcache = '0;
  assign m_awprot  = '0;
  assign m_awqos   = '0;
  assign m_wstrb   = '1;

  assign busy      = (state != ST_IDLE);
  assign err       = err_q;
  assign m_awvalid = awvalid_q;
  assign m_bready  = bready_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      state     <= ST_IDLE;
      awvalid_q <= 1'b0;
      bready_q  <= 1'b0;
      err_q     <= 1'b0;
      user_left <= '0;
      user_done <= 1'b0;
    end else begin
      bready_q <= 1'b1;
      unique case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_ADDR;
          awvalid_q <= 1'b1;
          user_left <= req_len;
          user_done <= 1'b0;
        end
        ST_ADDR: if (m_awready) begin
          awvalid_q <= 1'b0;
          state     <= ST_DATA;
        end
        ST_DATA: if (burst_end) state <= ST_RESP;
        ST_RESP: if (m_bvalid) begin
          if (m_bresp != RESP_OKAY) err_q <= 1'b1;
          if (user_done) begin
            state <= ST_IDLE;
          end else begin
            state     <= ST_ADDR;
            awvalid_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (take) begin
        user_left <= user_left - LEN_W'(1);
        if (wr_last || user_left == LEN_W'(1)) user_done <= 1'b1;
      end
    end
  end

  burst_addr_gen #(
    .ADDR_W(ADDR_W),
    .STRIDE(STRIDE)
  ) u_addr (
    .clk  (clk),
    .rst  (srst),
    .load (accept),
    .step (step),
    .start(req_addr),
    .limit(addr_limit),
    .addr (m_awaddr)
  );

  wbeat_feeder #(
    .DATA_W(DATA_W),
    .BEATS (BEATS)
  ) u_feed (
    .clk      (clk),
    .rst      (srst),
    .active   (state == ST_DATA),
    .more     (!user_done),
    .in_data  (wr_data),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .take     (take),
    .wdata    (m_wdata),
    .wvalid   (m_wvalid),
    .wlast    (m_wlast),
    .wready   (m_wready),
    .burst_end(burst_end)
  );
endmodule

// File: rtl/awb_checker.sv
module awb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 256,
  parameter int BEATS  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              init_done,
  input logic              busy,
  input logic              err,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wlast,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_bvalid,
  input logic              m_bready
);
  localparam int CW = $clog2(BEATS) + 1;

  logic [CW-1:0] beat_cnt;
  logic          aw_open;

  always_ff @(posedge clk) begin
    if (rst || !init_done) begin
      beat_cnt <= '0;
      aw_open  <= 1'b0;
    end else begin
      if (m_wvalid && m_wready) beat_cnt <= m_wlast ? '0 : beat_cnt + CW'(1);
      if (m_awvalid && m_awready) aw_open <= 1'b1;
      else if (m_bvalid && m_bready) aw_open <= 1'b0;
    end
  end

  // R10
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

  // R10
  w_hold_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    !busy |-> !m_awvalid && !m_wvalid && !wr_ready);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    err |=> err);

  // R5
  last_at_end_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    m_wvalid && m_wready && m_wlast |-> beat_cnt == CW'(BEATS - 1));

  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    m_wvalid && m_wready && !m_wlast |-> beat_cnt < CW'(BEATS - 1));

  // R6
  aw_after_b_chk: assert property (@(posedge clk) disable iff (rst || !init_done)
    m_awvalid |-> !aw_open);
endmodule

bind axi_burst_writer awb_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .BEATS (BEATS)
) u_awb_chk (
  .clk      (clk),
  .rst      (rst),
  .init_done(init_done),
  .busy     (busy),
  .err      (err),
  .wr_ready (wr_ready),
  .m_awaddr (m_awaddr),
  .m_awvalid(m_awvalid),
  .m_awready(m_awready),
  .m_wdata  (m_wdata),
  .m_wlast  (m_wlast),
  .m_wvalid (m_wvalid),
  .m_wready (m_wready),
  .m_bvalid (m_bvalid),
  .m_bready (m_bready)
);

// File: tb/axi_burst_writer_test.sv
module axi_burst_writer_test;
  localparam int AW = 32;
  localparam int DW = 256;
  localparam int BEATS = 256;
  localparam longint STRIDE = 8192;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, init_done = 1'b0;
  logic req_en = 1'b0;
  logic [AW-1:0] req_addr = '0, addr_limit = '1;
  logic [31:0] req_len = '0;
  logic busy, err;
  logic [DW-1:0] wr_data = '0;
  logic wr_valid = 1'b0, wr_last = 1'b0, wr_ready;
  logic [3:0] m_awid;
  logic [AW-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic m_awlock;
  logic [3:0] m_awcache;
  logic [2:0] m_awprot;
  logic [3:0] m_awqos;
  logic m_awvalid, m_awready = 1'b0;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic m_wlast, m_wvalid, m_wready = 1'b0;
  logic [1:0] m_bresp = 2'b00;
  logic m_bvalid = 1'b0, m_bready;

  axi_burst_writer uut (
    .clk(clk), .rst(rst), .init_done(init_done), .req_en(req_en),
    .req_addr(req_addr), .req_len(req_len), .addr_limit(addr_limit),
    .busy(busy), .err(err), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_last(wr_last), .wr_ready(wr_ready), .m_awid(m_awid),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awlock(m_awlock), .m_awcache(m_awcache),
    .m_awprot(m_awprot), .m_awqos(m_awqos), .m_awvalid(m_awvalid),
    .m_awready(m_awready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] exp_w[$];
  bit exp_l[$];
  longint exp_a[$];
  logic [DW-1:0] mem[longint];
  bit mbusy = 0, merr = 0;
  int mbursts = 0, aw_idx = 0;
  int cfg_tag = 0, cfg_last = -1, bresp_cfg = 0;
  bit bp_mode = 0, collide = 0;
  string cur_tag = "R4";
  bit ask_req = 0;
  logic [31:0] ask_addr = '0, ask_len = '0;
  int bwait = -1;
  bit b_taken = 0;
  logic [15:0] lfsr = 16'hACE1;
  longint cur_aw = 0, ea = 0;
  int wbeat = 0, cyc = 0;
  logic [DW-1:0] ed;
  bit el;

  function automatic logic [DW-1:0] pat(input int tag, input int k);
    logic [7:0] t8;
    logic [23:0] k24;
    t8 = tag[7:0];
    k24 = k[23:0];
    return {8{t8, k24}};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_accept();
    int ub, nb, idx;
    longint a, n;
    ub = (cfg_last >= 0 && cfg_last + 1 < int'(req_len)) ? cfg_last + 1 : int'(req_len);
    nb = (ub + BEATS - 1) / BEATS;
    a = longint'(req_addr);
    for (int b = 0; b < nb; b++) begin
      exp_a.push_back(a);
      for (int j = 0; j < BEATS; j++) begin
        idx = b * BEATS + j;
        exp_w.push_back(idx < ub ? pat(cfg_tag, idx) : '0);
        exp_l.push_back(j == BEATS - 1);
      end
      n = a + STRIDE;
      a = (n + STRIDE - 1 > longint'(addr_limit)) ? 0 : n;
    end
    mbusy = 1;
    mbursts = nb;
    aw_idx = 0;
  endtask

  // slave model, request driver and per-cycle comparison
  always begin
    @(negedge clk);
    cyc++;
    if (rst || !init_done)
      chk(!busy && !m_awvalid && !m_wvalid && !wr_ready && !err, "R1",
          "outputs held low in reset", {busy, m_awvalid, m_wvalid, wr_ready, err}, '0);
    else begin
      chk(busy == mbusy, "R9", "busy", busy, mbusy);
      chk(err == merr, "R11", "error flag", err, merr);
    end
    req_en = ask_req;
    req_addr = ask_addr;
    req_len = ask_len;
    ask_req = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_awready = bp_mode ? lfsr[0] : 1'b1;
    m_wready = bp_mode ? (lfsr[1] | lfsr[2]) : 1'b1;
    if (b_taken) begin
      m_bvalid = 0;
      b_taken = 0;
    end
    if (bwait > 0) begin
      bwait--;
      if (bwait == 0) begin
        m_bvalid = 1;
        m_bresp = bresp_cfg[1:0];
        bwait = -1;
        if (collide && mbursts == 1) begin
          req_en = 1;
          req_addr = 32'h0BAD_0000;
          req_len = 32'd9;
          collide = 0;
        end
      end
    end
    #1;
    if (rst || !init_done) begin
      mbusy = 0;
      merr = 0;
      exp_a.delete();
      exp_w.delete();
      exp_l.delete();
      m_bvalid = 0;
      bwait = -1;
    end else begin
      if (req_en && !mbusy && req_len != 0) model_accept();
      if (m_awvalid && m_awready) begin
        if (exp_a.size() == 0) chk(0, "R6", "unexpected burst address", m_awaddr, '0);
        else begin
          ea = exp_a.pop_front();
          chk(m_awaddr == ea[31:0], aw_idx == 0 ? "R2" : "R6", "burst address", m_awaddr, ea[31:0]);
        end
        chk(m_awlen == 8'hFF && m_awsize == 3'b101 && m_awburst == 2'b01, "R3",
            "len/size/burst", {m_awlen, m_awsize, m_awburst}, {8'hFF, 3'b101, 2'b01});
        chk(m_awid == 0 && !m_awlock && m_awcache == 0 && m_awprot == 0 && m_awqos == 0, "R3",
            "zero attributes", {m_awid, m_awlock, m_awcache, m_awprot, m_awqos}, '0);
        aw_idx++;
        cur_aw = longint'(m_awaddr);
        wbeat = 0;
      end
      if (m_wvalid && m_wready) begin
        if (exp_w.size() == 0) chk(0, "R4", "unexpected data beat", m_wdata, '0);
        else begin
          ed = exp_w.pop_front();
          el = exp_l.pop_front();
          chk(m_wdata == ed, cur_tag, "data beat", m_wdata, ed);
          chk(m_wlast == el, "R5", "last flag", m_wlast, el);
        end
        chk(&m_wstrb, "R3", "strobes", m_wstrb, {(DW/8){1'b1}});
        mem[cur_aw + 32 * wbeat] = m_wdata;
        wbeat++;
        if (m_wlast) bwait = 3;
      end
      if (m_bvalid && m_bready) begin
        b_taken = 1;
        if (m_bresp != 2'b00) merr = 1;
        if (mbusy) begin
          mbursts--;
          if (mbursts == 0) mbusy = 0;
        end
      end
    end
  end

  task automatic send_data(input int tag, input int n, input bit early, input bit gaps, input bit mid);
    int k;
    bit done_mid;
    k = 0;
    done_mid = 0;
    while (k < n) begin
      @(negedge clk);
      wr_valid = gaps ? (cyc % 5 != 2) : 1'b1;
      wr_data = pat(tag, k);
      wr_last = early && (k == n - 1);
      #1;
      if (mid && k == 20 && !done_mid) begin
        ask_addr = 32'hDEAD_0000;
        ask_len = 32'd40;
        ask_req = 1;
        done_mid = 1;
      end
      if (wr_valid && wr_ready) k++;
    end
    @(negedge clk);
    wr_valid = 0;
    wr_last = 0;
  endtask

  task automatic run(input int tag, input logic [31:0] addr, input int len, input int last_idx,
                     input logic [31:0] lim, input bit gaps, input bit bp, input bit mid,
                     input bit coll, input int bresp, input string rtag);
    int ub;
    @(posedge clk);
    cfg_tag = tag;
    cfg_last = last_idx;
    addr_limit = lim;
    bp_mode = bp;
    collide = coll;
    bresp_cfg = bresp;
    cur_tag = rtag;
    ask_addr = addr;
    ask_len = len;
    ask_req = 1;
    ub = (last_idx >= 0 && last_idx + 1 < len) ? last_idx + 1 : len;
    send_data(tag, ub, last_idx >= 0 && last_idx + 1 < len, gaps, mid);
    repeat (3) @(negedge clk);
    while (busy || mbusy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_a.size() == 0 && exp_w.size() == 0, rtag, "leftover expected bursts/beats",
        exp_a.size() + exp_w.size(), '0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    init_done = 1;
    repeat (2) @(negedge clk);
    // R4 single burst, R5 last flag, R3 attributes
    run(1, 32'h0000_1000, 256, -1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R4");
    // R10 backpressure both sides, partial final burst, R9 request ignored mid-transfer
    run(2, 32'h0010_0000, 600, -1, 32'hFFFF_FFFF, 1, 1, 1, 0, 0, "R10");
    // R2 zero length ignored
    run(3, 32'h0000_4000, 0, -1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R2");
    // R7 wrap to zero, R9 stray request in the final response cycle
    run(4, 32'h0000_2000, 700, -1, 32'h0000_5FFF, 0, 1, 0, 1, 0, "R7");
    chk(mem.exists(0) && mem[0] == pat(4, 512), "R7", "wrapped burst at 0",
        mem.exists(0) ? mem[0] : '0, pat(4, 512));
    chk(mem.exists(32'h4000) && mem[32'h4000] == pat(4, 256), "R6", "second burst base",
        mem.exists(32'h4000) ? mem[32'h4000] : '0, pat(4, 256));
    // R8 early end of user data
    run(5, 32'h0000_8000, 1000, 299, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R8");
    chk(mem.exists(32'hA000 + 32 * 43) && mem[32'hA000 + 32 * 43] == pat(5, 299), "R8",
        "final user beat", mem.exists(32'hA000 + 32 * 43) ? mem[32'hA000 + 32 * 43] : '0, pat(5, 299));
    chk(mem.exists(32'hA000 + 32 * 44) && mem[32'hA000 + 32 * 44] == '0, "R8",
        "fill beat after last", mem.exists(32'hA000 + 32 * 44) ? mem[32'hA000 + 32 * 44] : '1, '0);
    // R11 error response
    run(6, 32'h0002_0000, 512, -1, 32'hFFFF_FFFF, 0, 0, 0, 0, 2, "R11");
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R11", "error stays set", err, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule